// File: doc/BRIEF.md
# Capture and Reload Timer

This block is a 16-bit up-counting timer for a microcontroller-class subsystem. A run bit and a power-of-two clock divider set the count rate. The count climbs toward a programmable reload value. On the tick where the count equals that value, the count restarts at 0x0001 and the block pulses its interrupt.

In capture mode, an external input is synchronized and watched for one edge direction. On that edge the running count is copied into a 16-bit capture register and the same interrupt line pulses. A cause flag tells the handler which event fired: it is set by a capture and cleared by a reload. Software can therefore also clear the capture register beforehand and test it for zero afterwards. A single polarity bit picks the capture edge.

In PWM mode, the capture register holds the compare value instead. The same polarity bit then chooses whether the output is high above or at-and-below that value. All settings sit behind a byte-wide register port.

Top module: `capture_timer`

## Requirements
- R1: After synchronous reset the count and capture registers read 0x0000, the reload register reads 0xFFFF, the control byte reads 0x00, and `irq`, `irq_cap_cause` and `pwm_out` are low.
- R2: Registers are byte wide and are read combinationally on `reg_rdata`. The offsets are: 0 control, 1/2 count high/low, 3/4 reload high/low, 5/6 capture high/low, and 7 reads 0x00. Control bits are: [7] run, [6] polarity, [5:3] prescale N, [0] mode (0 capture, 1 PWM), and [1] the cause flag, which is read-only; writes to [1] and [2] are dropped. A write to a count byte lands at the next clock edge and overrides counting in that cycle.
- R3: While run is 1 the count advances by one every 2^N clocks, the first advance 2^N clocks after the edge that sets run. While run is 0 the count holds.
- R4: On a counting tick where count equals reload, the count becomes 0x0001 at that edge, `irq` is high for exactly the following cycle, and the cause flag is cleared.
- R5: In capture mode with polarity 0, a rising edge on `tmr_in` first passes two synchronizer flops. The edge is detected in the cycle after the second clock edge that follows the change. At the next clock edge the capture register takes the count of the detecting cycle, `irq` pulses for one cycle, the cause flag is set, and counting continues.
- R6: With polarity 0 a falling input edge is ignored. With polarity 1 a falling edge captures and a rising edge is ignored.
- R7: Input edges cause no capture and no interrupt while run is 0.
- R8: When a capture and a reload fall in the same cycle, the capture register is still written, the cause flag ends at 0, and a single one-cycle `irq` pulse results.
- R9: In PWM mode with run set, `pwm_out` is high when count > compare if polarity is 0, and when count <= compare if polarity is 1. In capture mode or with run clear, it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Write strobe for the addressed byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed byte |
| tmr_in | input | 1 | Asynchronous timer input |
| irq | output | 1 | One-cycle interrupt pulse |
| irq_cap_cause | output | 1 | Cause flag: 1 after a capture, 0 after a reload |
| pwm_out | output | 1 | PWM output |

## Verification
The capture and the reload can occur in the same cycle. This is the case that decides what the cause flag means. The bench forces the collision with the slowest prescale, N = 7, and a starting count equal to a reload of 3. It then places an input edge so that its detection cycle is exactly the one-hundred-and-twenty-eighth cycle after run is set, which is the only tick. The result passes only if the capture register holds 3, the count restarts at 1, the flag reads 0, and the scoreboard sees exactly one interrupt, carrying the reload cause.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CNT_W    = 2 * BYTE_W;
    localparam int unsigned PS_W     = 3;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned PS_CNT_W = (1 << PS_W) - 1;

    localparam logic [CNT_W-1:0] CNT_RESTART = CNT_W'(1);
    localparam logic [CNT_W-1:0] RLD_RESET   = '1;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL   = 3'd0,
        ADR_CNT_HI = 3'd1,
        ADR_CNT_LO = 3'd2,
        ADR_RLD_HI = 3'd3,
        ADR_RLD_LO = 3'd4,
        ADR_CMP_HI = 3'd5,
        ADR_CMP_LO = 3'd6,
        ADR_NONE   = 3'd7
    } reg_addr_e;

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_PWM     = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        logic            run;
        logic            sense;
        logic [PS_W-1:0] prescale;
        tmr_mode_e       mode;
    } ctrl_t;

    // Low N bits set: the divider terminal pattern for divide by 2^N.
    function automatic logic [PS_CNT_W-1:0] ps_mask(input logic [PS_W-1:0] sel);
        logic [PS_CNT_W-1:0] m;
        for (int i = 0; i < int'(PS_CNT_W); i++) begin
            m[i] = (i < int'(sel));
        end
        return m;
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c, input logic cause);
        return {c.run, c.sense, c.prescale, 1'b0, cause, c.mode};
    endfunction

    function automatic ctrl_t byte_to_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.run      = b[7];
        c.sense    = b[6];
        c.prescale = b[5:3];
        c.mode     = tmr_mode_e'(b[0]);
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] hi_byte(input logic [CNT_W-1:0] v);
        return v[CNT_W-1:BYTE_W];
    endfunction

    function automatic logic [BYTE_W-1:0] lo_byte(input logic [CNT_W-1:0] v);
        return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tcap_prescaler.sv
module tcap_prescaler
    import tcap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);

    logic [PS_CNT_W-1:0] div_q;
    logic [PS_CNT_W-1:0] mask;

    assign mask = ps_mask(sel);

    // Divider restarts from zero whenever the timer is stopped.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && ((div_q & mask) == mask);

endmodule

// File: rtl/tcap_edge_detect.sv
module tcap_edge_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic sense,
    output logic edge_hit
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= din;
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q[g] <= 1'b0;
            end else begin
                sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign settled = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
        end else begin
            last_q <= settled;
        end
    end

    // sense 0 selects rising edges, sense 1 falling edges.
    assign edge_hit = sense ? (last_q & ~settled) : (settled & ~last_q);

endmodule

// File: rtl/tcap_counter.sv
module tcap_counter
    import tcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CNT_W-1:0]  reload,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap  = tick && (cnt_q == reload);
    assign count = cnt_q;

    // A software write has priority over the counting step of that cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_hi || wr_lo) begin
            if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wdata;
            if (wr_lo) cnt_q[BYTE_W-1:0]     <= wdata;
        end else if (wrap) begin
            cnt_q <= CNT_RESTART;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tcap_pwm.sv
module tcap_pwm
    import tcap_pkg::*;
(
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic             sense,
    input  logic             active,
    output logic             pwm
);

    logic above;

    assign above = (count > cmp);
    assign pwm   = active && (sense ? !above : above);

endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import tcap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              tmr_in,
    output logic              irq,
    output logic              irq_cap_cause,
    output logic              pwm_out
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cmp_q;
    logic             cause_q;
    logic             irq_q;

    logic [CNT_W-1:0] count;
    logic             tick;
    logic             wrap;
    logic             edge_hit;
    logic             cap_ev;
    logic             run_on;
    logic             mode_pwm;
    logic             cnt_wr;

    reg_addr_e        adr;
    logic             wr_ctrl, wr_cnt_hi, wr_cnt_lo;
    logic             wr_rld_hi, wr_rld_lo, wr_cmp_hi, wr_cmp_lo;

    assign adr       = reg_addr_e'(reg_addr);
    assign wr_ctrl   = reg_wr && (adr == ADR_CTRL);
    assign wr_cnt_hi = reg_wr && (adr == ADR_CNT_HI);
    assign wr_cnt_lo = reg_wr && (adr == ADR_CNT_LO);
    assign wr_rld_hi = reg_wr && (adr == ADR_RLD_HI);
    assign wr_rld_lo = reg_wr && (adr == ADR_RLD_LO);
    assign wr_cmp_hi = reg_wr && (adr == ADR_CMP_HI);
    assign wr_cmp_lo = reg_wr && (adr == ADR_CMP_LO);
    assign cnt_wr    = wr_cnt_hi || wr_cnt_lo;

    assign run_on    = ctrl_q.run;
    assign mode_pwm  = (ctrl_q.mode == MODE_PWM);

    tcap_prescaler u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run_on),
        .sel  (ctrl_q.prescale),
        .tick (tick)
    );

    tcap_edge_detect #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .din      (tmr_in),
        .sense    (ctrl_q.sense),
        .edge_hit (edge_hit)
    );

    tcap_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .reload (reload_q),
        .wr_hi  (wr_cnt_hi),
        .wr_lo  (wr_cnt_lo),
        .wdata  (reg_wdata),
        .count  (count),
        .wrap   (wrap)
    );

    tcap_pwm u_pwm (
        .count  (count),
        .cmp    (cmp_q),
        .sense  (ctrl_q.sense),
        .active (run_on && mode_pwm),
        .pwm    (pwm_out)
    );

    assign cap_ev = edge_hit && run_on && !mode_pwm;

    // Control and reload registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= RLD_RESET;
        end else begin
            if (wr_ctrl)   ctrl_q                  <= byte_to_ctrl(reg_wdata);
            if (wr_rld_hi) reload_q[CNT_W-1:BYTE_W] <= reg_wdata;
            if (wr_rld_lo) reload_q[BYTE_W-1:0]     <= reg_wdata;
        end
    end

    // Capture / compare register: a hardware capture beats a software write.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (cap_ev) begin
            cmp_q <= count;
        end else begin
            if (wr_cmp_hi) cmp_q[CNT_W-1:BYTE_W] <= reg_wdata;
            if (wr_cmp_lo) cmp_q[BYTE_W-1:0]     <= reg_wdata;
        end
    end

    // Shared interrupt and its cause; reload decides the cause on a collision.
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            cause_q <= 1'b0;
        end else begin
            irq_q <= wrap || cap_ev;
            if (wrap) begin
                cause_q <= 1'b0;
            end else if (cap_ev) begin
                cause_q <= 1'b1;
            end
        end
    end

    assign irq           = irq_q;
    assign irq_cap_cause = cause_q;

    always_comb begin
        reg_rdata = '0;
        case (adr)
            ADR_CTRL:   reg_rdata = ctrl_to_byte(ctrl_q, cause_q);
            ADR_CNT_HI: reg_rdata = hi_byte(count);
            ADR_CNT_LO: reg_rdata = lo_byte(count);
            ADR_RLD_HI: reg_rdata = hi_byte(reload_q);
            ADR_RLD_LO: reg_rdata = lo_byte(reload_q);
            ADR_CMP_HI: reg_rdata = hi_byte(cmp_q);
            ADR_CMP_LO: reg_rdata = lo_byte(cmp_q);
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tcap_timer_chk.sv
module tcap_timer_chk
    import tcap_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             pwm_mode,
    input logic             tick,
    input logic             wrap,
    input logic             cap_ev,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cmp,
    input logic             irq,
    input logic             cause,
    input logic             pwm_out
);

    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(count));

    a_r4_wrap_restart: assert property (@(posedge clk) disable iff (rst)
        (wrap && !cnt_wr) |=> (count == CNT_RESTART));

    a_r4_wrap_irq: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (irq && !cause));

    a_r4_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(wrap || cap_ev));

    a_r5_capture_latch: assert property (@(posedge clk) disable iff (rst)
        (cap_ev && !wrap) |=> (irq && cause && cmp == $past(count)));

    a_r5_keeps_counting: assert property (@(posedge clk) disable iff (rst)
        (cap_ev && tick && !wrap && !cnt_wr) |=> (count == CNT_W'($past(count) + 1'b1)));

    a_r8_reload_wins: assert property (@(posedge clk) disable iff (rst)
        (cap_ev && wrap) |=> (!cause && irq && cmp == $past(count)));

    a_r9_pwm_idle: assert property (@(posedge clk) disable iff (rst)
        !(run && pwm_mode) |-> !pwm_out);

endmodule

bind capture_timer tcap_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run_on),
    .pwm_mode (mode_pwm),
    .tick     (tick),
    .wrap     (wrap),
    .cap_ev   (cap_ev),
    .cnt_wr   (cnt_wr),
    .count    (count),
    .cmp      (cmp_q),
    .irq      (irq),
    .cause    (irq_cap_cause),
    .pwm_out  (pwm_out)
);

// File: tb/capture_timer_tb.sv
module capture_timer_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_CNT  = 3'd1;
    localparam logic [2:0] A_RLD  = 3'd3;
    localparam logic [2:0] A_CMP  = 3'd5;
    localparam logic [2:0] A_NONE = 3'd7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tmr_in = 1'b0;
    logic       irq;
    logic       irq_cap_cause;
    logic       pwm_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    // Scoreboard: expected cause value of each interrupt, in order.
    logic exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    capture_timer u_dut (
        .clk           (clk),
        .rst           (rst),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .tmr_in        (tmr_in),
        .irq           (irq),
        .irq_cap_cause (irq_cap_cause),
        .pwm_out       (pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] d);
        wr(a, d[15:8]);
        wr(3'(a + 3'd1), d[7:0]);
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v[15:8] = reg_rdata;
        reg_addr = 3'(a + 3'd1);
        #1;
        v[7:0] = reg_rdata;
    endtask

    function automatic logic [7:0] cb(input logic run, input logic sense,
                                      input logic [2:0] ps, input logic mode);
        return {run, sense, ps, 1'b0, 1'b0, mode};
    endfunction

    // Monitor: each interrupt pulse is matched against the scoreboard.
    always @(negedge clk) begin
        if (!rst && irq) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R4/R5/R8: actual unexpected irq expected none at %0t", $time);
            end else begin
                logic e;
                e = exp_q.pop_front();
                if (irq_cap_cause !== e) begin
                    n_errors++;
                    $display("FAIL R4/R5/R8 cause: actual %0b expected %0b at %0t",
                             irq_cap_cause, e, $time);
                end
            end
        end
    end

    task automatic finish_run();
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R4/R8 missing irq: actual %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    // PWM run: start at count 1 with reload 4, check nine cycles.
    task automatic pwm_run(input logic sense, input logic [15:0] cmp_v);
        logic [15:0] v;
        logic [15:0] c;
        wr16(A_CNT, 16'h0001);
        exp_q.push_back(1'b0);
        exp_q.push_back(1'b0);
        wr(A_CTRL, cb(1'b1, sense, 3'd0, 1'b1));
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            c = 16'((i % 4) + 1);
            rd16(A_CNT, v);
            check("R9 count", v, c);
            if (sense == 1'b0) check("R9 pwm pol0", pwm_out, c > cmp_v);
            else               check("R9 pwm pol1", pwm_out, c <= cmp_v);
        end
        wr(A_CTRL, cb(1'b0, sense, 3'd0, 1'b1));
        check("R9 stopped low", pwm_out, 1'b0);
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] cap;
        logic [7:0]  b;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd16(A_CNT, v); check("R1 count", v, 16'h0000);
        rd16(A_RLD, v); check("R1 reload", v, 16'hFFFF);
        rd16(A_CMP, v); check("R1 capture", v, 16'h0000);
        rd8(A_CTRL, b); check("R1 ctrl", b, 8'h00);
        check("R1 irq", irq, 1'b0);
        check("R1 cause", irq_cap_cause, 1'b0);
        check("R1 pwm", pwm_out, 1'b0);

        // R2 register access
        wr16(A_CNT, 16'h1234);
        rd16(A_CNT, v); check("R2 count write", v, 16'h1234);
        wr(A_CTRL, 8'h2B);
        rd8(A_CTRL, b); check("R2 ctrl ro bits", b, 8'h29);
        rd8(A_NONE, b); check("R2 unused offset", b, 8'h00);
        wr(A_CTRL, 8'h00);

        // R3 prescale N=3: advance at edges 8 and 16 after run
        wr16(A_CNT, 16'h0001);
        wr(A_CTRL, cb(1'b1, 1'b0, 3'd3, 1'b0));
        rd16(A_CNT, v); check("R3 start", v, 16'h0001);
        repeat (7) @(negedge clk);
        rd16(A_CNT, v); check("R3 before tick", v, 16'h0001);
        @(negedge clk);
        rd16(A_CNT, v); check("R3 first tick", v, 16'h0002);
        repeat (8) @(negedge clk);
        rd16(A_CNT, v); check("R3 second tick", v, 16'h0003);
        wr(A_CTRL, cb(1'b0, 1'b0, 3'd3, 1'b0));
        repeat (20) @(negedge clk);
        rd16(A_CNT, v); check("R3 hold when stopped", v, 16'h0003);

        // R4 reload 4, N=0: wrap at edges 4 and 8
        wr16(A_RLD, 16'h0004);
        wr16(A_CNT, 16'h0001);
        exp_q.push_back(1'b0);
        exp_q.push_back(1'b0);
        wr(A_CTRL, cb(1'b1, 1'b0, 3'd0, 1'b0));
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            rd16(A_CNT, v);
            check("R4 count sequence", v, 16'((i % 4) + 1));
            check("R4 irq pulse", irq, (i == 4) || (i == 8));
        end
        wr(A_CTRL, cb(1'b0, 1'b0, 3'd0, 1'b0));
        check("R4 cause after reload", irq_cap_cause, 1'b0);
        wr16(A_RLD, 16'hFFFF);

        // R5 rising-edge capture, polarity 0
        wr16(A_CMP, 16'h0000);
        wr16(A_CNT, 16'h0001);
        exp_q.push_back(1'b1);
        wr(A_CTRL, cb(1'b1, 1'b0, 3'd0, 1'b0));
        tmr_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd16(A_CNT, cap);
        @(negedge clk);
        check("R5 irq", irq, 1'b1);
        check("R5 cause set", irq_cap_cause, 1'b1);
        rd16(A_CMP, v); check("R5 captured count", v, cap);
        rd16(A_CNT, v); check("R5 counting continues", v, 16'(cap + 16'd1));
        check("R9 low in capture mode", pwm_out, 1'b0);

        // R6 falling edge ignored with polarity 0
        tmr_in = 1'b0;
        repeat (5) @(negedge clk);
        rd16(A_CMP, v); check("R6 falling ignored pol0", v, cap);

        // R6 polarity 1: rising ignored, falling captures
        wr(A_CTRL, cb(1'b0, 1'b1, 3'd0, 1'b0));
        wr16(A_CMP, 16'h0000);
        wr(A_CTRL, cb(1'b1, 1'b1, 3'd0, 1'b0));
        tmr_in = 1'b1;
        repeat (5) @(negedge clk);
        rd16(A_CMP, v); check("R6 rising ignored pol1", v, 16'h0000);
        exp_q.push_back(1'b1);
        tmr_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd16(A_CNT, cap);
        @(negedge clk);
        rd16(A_CMP, v); check("R6 falling capture pol1", v, cap);

        // R7 edges while stopped
        wr(A_CTRL, cb(1'b0, 1'b1, 3'd0, 1'b0));
        wr16(A_CMP, 16'h0000);
        tmr_in = 1'b1;
        repeat (4) @(negedge clk);
        tmr_in = 1'b0;
        repeat (5) @(negedge clk);
        rd16(A_CMP, v); check("R7 no capture when stopped", v, 16'h0000);

        // R8 capture and reload in the same cycle (N=7, tick after edge 127)
        wr(A_CTRL, cb(1'b0, 1'b0, 3'd7, 1'b0));
        wr16(A_RLD, 16'h0003);
        wr16(A_CNT, 16'h0003);
        exp_q.push_back(1'b0);
        wr(A_CTRL, cb(1'b1, 1'b0, 3'd7, 1'b0));
        repeat (125) @(negedge clk);
        rd16(A_CNT, v); check("R8 count before collision", v, 16'h0003);
        tmr_in = 1'b1;
        repeat (3) @(negedge clk);
        rd16(A_CMP, v); check("R8 capture still written", v, 16'h0003);
        rd16(A_CNT, v); check("R8 count restarted", v, 16'h0001);
        check("R8 cause reload", irq_cap_cause, 1'b0);
        wr(A_CTRL, cb(1'b0, 1'b0, 3'd7, 1'b0));

        // R9 PWM with reload 4 and compare 1
        wr16(A_RLD, 16'h0004);
        wr16(A_CMP, 16'h0001);
        pwm_run(1'b0, 16'h0001);
        pwm_run(1'b1, 16'h0001);

        repeat (4) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule